// File: doc/BRIEF.md
# Data Access Fault Capture Unit

This unit sits beside a CPU load/store pipeline and watches every data access as it completes. It flags two kinds of fault. The first is an access to a system register made while the CPU runs in user mode. The second is a bus error response to a data access. The first fault of a burst is recorded in a capture register pair: one register holds the faulting address and the other holds a status word. The pair then stays frozen until software acknowledges it.

Each fault leads to one outcome, chosen from how the access was made:

- A user-mode system-register access raises a precise illegal-instruction exception.
- A bus error on an unbufferable access also raises that exception.
- A bus error on a bufferable access can only be reported late, so it raises a level interrupt, and only when software has enabled it.
- A precise fault during exception entry or interrupt return halts the CPU. Only a break interrupt or a reset releases the halt.

The unit also tracks which registers of a multi-register transfer are still outstanding. When a precise fault hits such a transfer, it copies that list into an exception status register.

Top module: `dacc_fault_top`

## Requirements
- R1: An access with `accValid`=1 is a fault when (`accSysReg` and `userMode`) or `busErr` is 1. When a fault is captured, `errAddr` takes `accAddr`. `errStatus` takes bit0=1 (valid), bit1=`accWrite`, bit2=`busErr`, bit3=`accBufferable`, bit4=`userMode`, bit5=`inMultiXfer`, bit6=system-register violation, bit7=0.
- R2: While `errStatus` bit0 is 1, a new fault leaves `errAddr` and `errStatus` unchanged, unless the same cycle clears the flag (see R8).
- R3: A user-mode system-register access pulses `illegalExc` for one cycle in the cycle after the access, whatever `accBufferable` is.
- R4: A bus error on an access with `accBufferable`=0 pulses `illegalExc` in the cycle after the access.
- R5: A bus error on a bufferable access with `irqEnable`=1 raises no exception. It sets a pending bit, and `daeIrq` is 1 while that bit, the valid flag and `irqEnable` are all 1.
- R6: A bus error on a bufferable access with `irqEnable`=0 only updates the capture registers, if they are free. `illegalExc` and `daeIrq` stay 0.
- R7: `regWrEn`=1 with `regWrSel`=0 loads `irqEnable` from `regWrBit`. With `regWrSel`=1 and `regWrBit`=1, it clears `errStatus` to 0 and clears the pending interrupt. `errAddr` is kept.
- R8: When a fault and a clear of the valid flag fall in the same cycle, the fault is captured and the flag stays 1.
- R9: `xferStart` loads the outstanding-register mask from `xferMask`. Each non-faulting access with `inMultiXfer`=1 clears mask bit `xferRegIdx`. A precise fault with `inMultiXfer`=1 writes `excStatus[15:0]` with the mask, including the faulting register, and sets `excStatus[16]`.
- R10: A precise fault with `inEntryReturn`=1 sets `cpuHalt` in the next cycle. `cpuHalt` then holds until `breakIrq` is 1 or a reset occurs.
- R11: After reset, all outputs are 0.
- R12: `regWrEn`=1 with `regWrSel`=2 and `regWrBit`=1 clears `excStatus`, unless a precise multi-transfer fault occurs in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | A data access completes this cycle |
| accAddr | input | ADDR_W | Address of the access |
| accWrite | input | 1 | Access is a store |
| accSysReg | input | 1 | Access targets a system register |
| userMode | input | 1 | CPU is in user mode |
| accBufferable | input | 1 | Access is to a bufferable area |
| busErr | input | 1 | Bus returned an error for the access |
| inMultiXfer | input | 1 | Access belongs to a multi-register transfer |
| xferStart | input | 1 | Load the outstanding-register mask |
| xferMask | input | NREG | Register list of the new transfer |
| xferRegIdx | input | $clog2(NREG) | Register index of the current transfer element |
| inEntryReturn | input | 1 | Access belongs to exception entry or interrupt return |
| breakIrq | input | 1 | Break interrupt, releases the halt |
| regWrEn | input | 1 | Software register write strobe |
| regWrSel | input | 2 | 0 control, 1 error status, 2 exception status |
| regWrBit | input | 1 | Write data bit |
| illegalExc | output | 1 | Precise illegal-instruction exception pulse |
| daeIrq | output | 1 | Imprecise data-access-error interrupt level |
| cpuHalt | output | 1 | CPU halt request |
| errAddr | output | ADDR_W | Captured faulting address |
| errStatus | output | 8 | Captured status word |
| excStatus | output | NREG+1 | Outstanding register list and fault bit |
| irqEnable | output | 1 | Interrupt enable bit |

## Verification
Two pairs of events can collide in one cycle, and the bench provokes both on purpose. The first pair is a fault and a software clear of the valid flag. A directed step drives both in one cycle. The bench then expects the new address and status to be captured, with the flag left at 1. The second pair is a precise multi-transfer fault and a clear of the exception status register. Here the bench expects the fault's register list to win. Random traffic later hits both pairs again by chance, and each cycle is judged against a reference model in the bench.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  localparam int STATUS_W = 8;
  localparam int ST_VALID = 0;

  typedef struct packed {
    logic capture;   // load address and status
    logic setPend;   // imprecise interrupt becomes pending
    logic clrFlag;   // software clear of valid flag
    logic loadMask;  // new multi-register transfer
    logic retire;    // one transfer element completed
    logic latchRl;   // copy outstanding list into exception status
    logic clrEsr;    // software clear of exception status
    logic wrCtrl;    // write of interrupt enable
  } strobe_t;
endpackage

// File: rtl/dacc_ctrl.sv
module dacc_ctrl
  import dacc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    accValid,
  input  logic    accSysReg,
  input  logic    userMode,
  input  logic    accBufferable,
  input  logic    busErr,
  input  logic    inMultiXfer,
  input  logic    xferStart,
  input  logic    inEntryReturn,
  input  logic    breakIrq,
  input  logic    regWrEn,
  input  logic [1:0] regWrSel,
  input  logic    regWrBit,
  input  logic    validQ,
  input  logic    irqEnQ,
  output strobe_t stb,
  output logic    illegalExc,
  output logic    cpuHalt
);
  logic sysViol, busFault, anyFault, precise, imprecise, clrReq;
  logic illegalExcQ, haltQ;

  always_comb begin
    sysViol   = accValid && accSysReg && userMode;
    busFault  = accValid && busErr;
    anyFault  = sysViol || busFault;
    precise   = sysViol || (busFault && !accBufferable);
    imprecise = busFault && accBufferable && !sysViol && irqEnQ;
    clrReq    = regWrEn && (regWrSel == 2'd1) && regWrBit;

    stb          = '0;
    stb.clrFlag  = clrReq;
    stb.capture  = anyFault && (!validQ || clrReq);
    stb.setPend  = imprecise;
    stb.loadMask = xferStart;
    stb.retire   = accValid && inMultiXfer && !precise && !xferStart;
    stb.latchRl  = precise && inMultiXfer;
    stb.clrEsr   = regWrEn && (regWrSel == 2'd2) && regWrBit;
    stb.wrCtrl   = regWrEn && (regWrSel == 2'd0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      illegalExcQ <= 1'b0;
      haltQ       <= 1'b0;
    end else begin
      illegalExcQ <= precise;
      if (precise && inEntryReturn) haltQ <= 1'b1;
      else if (breakIrq)            haltQ <= 1'b0;
    end
  end

  assign illegalExc = illegalExcQ;
  assign cpuHalt    = haltQ;

  assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (haltQ && !breakIrq) |=> haltQ);

  assert_exc_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    illegalExcQ |-> $past(accValid));

  assert_buf_no_exc_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && busErr && accBufferable && !(accSysReg && userMode)) |=> !illegalExcQ);
endmodule

// File: rtl/dacc_dpath.sv
module dacc_dpath
  import dacc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG   = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  input  logic              accSysReg,
  input  logic              userMode,
  input  logic              accBufferable,
  input  logic              busErr,
  input  logic              inMultiXfer,
  input  logic [NREG-1:0]   xferMask,
  input  logic [IDX_W-1:0]  xferRegIdx,
  input  logic              regWrBit,
  output logic              validQ,
  output logic              irqEnQ,
  output logic              daeIrq,
  output logic [ADDR_W-1:0] errAddr,
  output logic [STATUS_W-1:0] errStatus,
  output logic [NREG:0]     excStatus
);
  logic [ADDR_W-1:0]   addrQ;
  logic [STATUS_W-1:0] statQ, statNew;
  logic                pendQ;
  logic [NREG-1:0]     remQ;
  logic [NREG:0]       esrQ;

  always_comb begin
    statNew    = '0;
    statNew[0] = 1'b1;
    statNew[1] = accWrite;
    statNew[2] = busErr;
    statNew[3] = accBufferable;
    statNew[4] = userMode;
    statNew[5] = inMultiXfer;
    statNew[6] = accSysReg && userMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      statQ <= '0;
    end else if (stb.capture) begin
      addrQ <= accAddr;
      statQ <= statNew;
    end else if (stb.clrFlag) begin
      statQ <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             pendQ <= 1'b0;
    else if (stb.setPend)                  pendQ <= 1'b1;
    else if (stb.clrFlag && !stb.capture)  pendQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           irqEnQ <= 1'b0;
    else if (stb.wrCtrl) irqEnQ <= regWrBit;
  end

  // outstanding register list, one bit per register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) remQ <= '0;
    else if (stb.loadMask) remQ <= xferMask;
    else if (stb.retire) begin
      for (int i = 0; i < NREG; i++)
        if (IDX_W'(i) == xferRegIdx) remQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            esrQ <= '0;
    else if (stb.latchRl) esrQ <= {1'b1, remQ};
    else if (stb.clrEsr)  esrQ <= '0;
  end

  assign validQ    = statQ[ST_VALID];
  assign errAddr   = addrQ;
  assign errStatus = statQ;
  assign excStatus = esrQ;
  assign daeIrq    = pendQ && validQ && irqEnQ;

  assert_sticky_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && !stb.clrFlag) |=> $stable(addrQ));

  assert_sticky_stat_R2: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && !stb.clrFlag) |=> $stable(statQ));

  assert_pend_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendQ) |-> $past(accValid && busErr && accBufferable));

  assert_rl_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(esrQ[NREG]) |-> $past(accValid && inMultiXfer));
endmodule

// File: rtl/dacc_fault_top.sv
module dacc_fault_top
  import dacc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG   = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  input  logic              accSysReg,
  input  logic              userMode,
  input  logic              accBufferable,
  input  logic              busErr,
  input  logic              inMultiXfer,
  input  logic              xferStart,
  input  logic [NREG-1:0]   xferMask,
  input  logic [IDX_W-1:0]  xferRegIdx,
  input  logic              inEntryReturn,
  input  logic              breakIrq,
  input  logic              regWrEn,
  input  logic [1:0]        regWrSel,
  input  logic              regWrBit,
  output logic              illegalExc,
  output logic              daeIrq,
  output logic              cpuHalt,
  output logic [ADDR_W-1:0] errAddr,
  output logic [STATUS_W-1:0] errStatus,
  output logic [NREG:0]     excStatus,
  output logic              irqEnable
);
  strobe_t stb;
  logic    validQ, irqEnQ;

  dacc_ctrl u_ctrl (
    .clk, .rstN, .accValid, .accSysReg, .userMode, .accBufferable, .busErr,
    .inMultiXfer, .xferStart, .inEntryReturn, .breakIrq, .regWrEn, .regWrSel,
    .regWrBit, .validQ, .irqEnQ, .stb, .illegalExc, .cpuHalt
  );

  dacc_dpath #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dpath (
    .clk, .rstN, .stb, .accValid, .accAddr, .accWrite, .accSysReg, .userMode,
    .accBufferable, .busErr, .inMultiXfer, .xferMask, .xferRegIdx, .regWrBit,
    .validQ, .irqEnQ, .daeIrq, .errAddr, .errStatus, .excStatus
  );

  assign irqEnable = irqEnQ;
endmodule

// File: tb/dacc_fault_top_test.sv
module dacc_fault_top_test;
  localparam int AW = 32;
  localparam int NR = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic accValid, accWrite, accSysReg, userMode, accBufferable, busErr;
  logic inMultiXfer, xferStart, inEntryReturn, breakIrq, regWrEn, regWrBit;
  logic [AW-1:0] accAddr;
  logic [NR-1:0] xferMask;
  logic [3:0]    xferRegIdx;
  logic [1:0]    regWrSel;
  logic illegalExc, daeIrq, cpuHalt, irqEnable;
  logic [AW-1:0] errAddr;
  logic [7:0]    errStatus;
  logic [NR:0]   excStatus;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  logic [AW-1:0] mAddr; logic [7:0] mStat; logic mPend, mEn, mIll, mHalt;
  logic [NR-1:0] mRem; logic [NR:0] mEsr;

  always #5 clk = ~clk;

  dacc_fault_top uut (.*);

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    accValid = 0; accWrite = 0; accSysReg = 0; userMode = 0; accBufferable = 0;
    busErr = 0; inMultiXfer = 0; xferStart = 0; inEntryReturn = 0; breakIrq = 0;
    regWrEn = 0; regWrBit = 0; regWrSel = 0; accAddr = '0; xferMask = '0; xferRegIdx = '0;
  endtask

  function automatic logic [7:0] statWord();
    return {1'b0, accSysReg & userMode, inMultiXfer, userMode, accBufferable, busErr, accWrite, 1'b1};
  endfunction

  // advance one cycle: update model from driven inputs, then compare all outputs
  task automatic step(string tag);
    logic sysv, berr, prec, imp, clr, cap;
    sysv = accValid & accSysReg & userMode;
    berr = accValid & busErr;
    prec = sysv | (berr & ~accBufferable);
    imp  = berr & accBufferable & ~sysv & mEn;
    clr  = regWrEn && regWrSel == 2'd1 && regWrBit;
    cap  = (sysv | berr) & (~mStat[0] | clr);
    if (cap) begin mAddr = accAddr; mStat = statWord(); end
    else if (clr) mStat = '0;
    if (imp) mPend = 1; else if (clr && !cap) mPend = 0;
    if (regWrEn && regWrSel == 2'd0) mEn = regWrBit;
    if (prec && inMultiXfer) mEsr = {1'b1, mRem};
    else if (regWrEn && regWrSel == 2'd2 && regWrBit) mEsr = '0;
    if (xferStart) mRem = xferMask;
    else if (accValid && inMultiXfer && !prec) mRem[xferRegIdx] = 1'b0;
    mIll = prec;
    if (prec && inEntryReturn) mHalt = 1; else if (breakIrq) mHalt = 0;
    @(posedge clk); #1;
    chk(tag, "illegalExc", 64'(illegalExc), 64'(mIll));
    chk(tag, "daeIrq", 64'(daeIrq), 64'(mPend & mStat[0] & mEn));
    chk(tag, "cpuHalt", 64'(cpuHalt), 64'(mHalt));
    chk(tag, "errAddr", 64'(errAddr), 64'(mAddr));
    chk(tag, "errStatus", 64'(errStatus), 64'(mStat));
    chk(tag, "excStatus", 64'(excStatus), 64'(mEsr));
    chk(tag, "irqEnable", 64'(irqEnable), 64'(mEn));
    @(negedge clk);
    idle();
  endtask

  task automatic acc(logic [AW-1:0] a, logic sys, logic usr, logic buff, logic be);
    accValid = 1; accAddr = a; accSysReg = sys; userMode = usr; accBufferable = buff; busErr = be;
  endtask

  task automatic wr(logic [1:0] sel, logic b);
    regWrEn = 1; regWrSel = sel; regWrBit = b;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    idle();
    mAddr = 0; mStat = 0; mPend = 0; mEn = 0; mIll = 0; mHalt = 0; mRem = 0; mEsr = 0;
    repeat (3) @(negedge clk);
    chk("R11", "reset all", 64'({illegalExc, daeIrq, cpuHalt, irqEnable, errStatus}) | 64'(errAddr) | 64'(excStatus), 0);
    rstN = 1; @(negedge clk);
    step("R11");
    // R3: user-mode system register on bufferable area -> precise exception
    acc(32'h1000_0010, 1, 1, 1, 0); step("R3");
    step("R3 pulse end");
    wr(1, 1); step("R7 clear");
    // R4: unbufferable bus error
    acc(32'h2000_0020, 0, 0, 0, 1); accWrite = 1; step("R4");
    // R2: sticky, second fault ignored
    acc(32'h3000_0030, 1, 1, 0, 1); step("R2");
    // R8: fault and clear same cycle -> capture wins
    acc(32'h4000_0040, 0, 1, 0, 1); wr(1, 1); step("R8");
    wr(1, 1); step("R7");
    // R5: bufferable bus error with enable
    wr(0, 1); step("R7 enable");
    acc(32'h5000_0050, 0, 0, 1, 1); step("R5");
    step("R5 level held");
    wr(0, 0); step("R5 enable drop");
    wr(0, 1); step("R5 enable back");
    wr(1, 1); step("R7 irq clear");
    wr(0, 0); step("R7");
    // R6: bufferable without enable
    acc(32'h6000_0060, 0, 0, 1, 1); step("R6");
    wr(1, 1); step("R6 clear");
    // R9: multi-register transfer
    xferStart = 1; xferMask = 16'h00f3; step("R9 load");
    accValid = 1; inMultiXfer = 1; xferRegIdx = 0; step("R9 retire");
    accValid = 1; inMultiXfer = 1; xferRegIdx = 1; step("R9 retire");
    acc(32'h7000_0070, 0, 0, 0, 1); inMultiXfer = 1; xferRegIdx = 4; wr(2, 1); step("R9 vs R12");
    wr(2, 1); step("R12");
    wr(1, 1); step("R1 clear");
    // R10: halt on entry/return, held until break
    acc(32'h8000_0080, 1, 1, 0, 0); inEntryReturn = 1; step("R10");
    step("R10 hold");
    breakIrq = 1; step("R10 break");
    wr(1, 1); step("R1");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      accValid = r[0]; accWrite = r[1]; accSysReg = r[2] & r[3]; userMode = r[4];
      accBufferable = r[5]; busErr = r[6] & r[7]; inMultiXfer = r[8];
      xferStart = (r[12:9] == 0); xferMask = 16'($urandom); xferRegIdx = r[16:13];
      inEntryReturn = (r[19:17] == 0); breakIrq = (r[22:20] == 0);
      regWrEn = r[23] & r[24]; regWrSel = r[26:25] == 3 ? 2'd1 : r[26:25]; regWrBit = r[27] | r[28];
      accAddr = $urandom;
      step("R1 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule